// File: doc/BRIEF.md
# Fairness-Interval Bus Arbiter for a Tree of Nodes

This block sits at the root of a tree-shaped serial bus and decides which attached node may transmit next. Each node slot has a request line and a release line. It also has a static configuration: an urgency bit, its distance from the root in hops and a 6-bit node identifier. The arbiter hands the bus to exactly one slot at a time and keeps it there until that slot signals that it is finished.

Ordering is by waiting time. The slot that has been asking longest wins. Slots that began asking in the same cycle are ordered by hop count, with fewer hops first, and then by the lower identifier. A per-slot permission flag limits ordinary slots to one turn per fairness round. A round ends and a new one opens once nobody holding permission is still asking. Urgent slots may take extra turns after their permission is spent. The number of such turns is bounded against the turns given to ordinary slots.

Top module: `fair_tree_arbiter`

## Requirements
- R1: During and after a synchronous active-high reset, `grant_o` is all zero, `grant_id_o` is zero and `interval_start_o` is low. The urgent-turn count is zero and every permission flag is set, so a lone request raised right after reset is granted at the first clock edge.
- R2: `grant_o` is one-hot or zero, and bit i means slot i owns the bus. While a slot owns the bus, `grant_o` and `grant_id_o` stay unchanged until that slot's release bit is sampled high. Release pulses from other slots have no effect. `grant_id_o` carries the owner's identifier, or zero when the bus is idle.
- R3: At the clock edge that samples the owner's release bit, the grant is withdrawn. The next grant can be issued no earlier than the edge after that, so every handover has at least one idle cycle.
- R4: Among eligible requesters, the one whose request line has been high for the most cycles wins.
- R5: Requesters of equal waiting time are ordered by hop count, and the smaller count wins.
- R6: Requesters of equal waiting time and equal hop count are ordered by identifier, and the smaller identifier wins.
- R7: A granted slot loses its permission flag. A non-urgent slot without permission is never granted, even if it is the oldest requester, until a new round opens.
- R8: A new round opens when the bus is idle, at least one permission flag is clear and no requester holds permission. At that edge every flag is set, no grant is issued, and `interval_start_o` is high for exactly the following cycle.
- R9: A slot whose urgency bit is 1 may be granted without permission, provided the urgent-turn limit does not block it.
- R10: Every grant to an urgent slot adds one to an urgent-turn count, which saturates at RATIO (default 3). A grant to a non-urgent slot clears the count. While a non-urgent slot with permission is asking and the count equals RATIO, no urgent slot without permission is granted.
- R11: When no non-urgent slot with permission is asking, the urgent-turn count does not block urgent slots.
- R12: A slot that drops its request before being granted loses its accumulated waiting time. If it asks again, it is ordered as a fresh arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_NODES | Per-slot request, held high while the slot wants the bus |
| release_i | input | N_NODES | Per-slot release pulse; only the owner's bit is acted on |
| urgent_i | input | N_NODES | Per-slot urgency configuration bit |
| depth_i | input | N_NODES*DEPTH_W | Per-slot hop count to the root, slot i at bits [i*DEPTH_W +: DEPTH_W] |
| node_id_i | input | N_NODES*ID_W | Per-slot identifier, slot i at bits [i*ID_W +: ID_W]; the all-ones value is reserved |
| grant_o | output | N_NODES | One-hot bus ownership |
| grant_id_o | output | ID_W | Identifier of the current owner, zero when idle |
| interval_start_o | output | 1 | One-cycle pulse after a new fairness round opens |

## Verification
The properties assume that release pulses come only from a slot that currently owns the bus, or are otherwise harmless. They also assume that hop counts and identifiers stay constant while requests are in flight, and that every identifier is unique and not the reserved all-ones value. The stimulus holds the configuration buses fixed for the whole run and gives each slot a distinct identifier below 63. Requests and releases change only on the falling edge. Scenarios are arranged so that waiting times never approach the age counter's saturation point, which keeps the ordering strictly first-come-first-served.

// File: rtl/fta_pkg.sv
package fta_pkg;

  // True when candidate A is ordered ahead of candidate B:
  // longer waiting time first, then fewer hops, then smaller identifier.
  function automatic logic ahead_of(
    input logic [31:0] age_a,
    input logic [31:0] hop_a,
    input logic [31:0] nid_a,
    input logic [31:0] age_b,
    input logic [31:0] hop_b,
    input logic [31:0] nid_b
  );
    if (age_a != age_b) return age_a > age_b;
    if (hop_a != hop_b) return hop_a < hop_b;
    return nid_a < nid_b;
  endfunction

endpackage

// File: rtl/fta_age_track.sv
module fta_age_track #(
  parameter int N_NODES = 8,
  parameter int AGE_W   = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_NODES-1:0]       req,
  input  logic [N_NODES-1:0]       owner_mask,
  input  logic [N_NODES-1:0]       grant_now,
  output logic [N_NODES*AGE_W-1:0] ages
);

  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  for (genvar g = 0; g < N_NODES; g++) begin : g_slot
    logic [AGE_W-1:0] age_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        age_q <= '0;
      end else if (!req[g] || owner_mask[g] || grant_now[g]) begin
        age_q <= '0;
      end else if (age_q != AGE_MAX) begin
        age_q <= age_q + 1'b1;
      end
    end

    assign ages[g*AGE_W +: AGE_W] = age_q;
  end

endmodule

// File: rtl/fta_pick.sv
module fta_pick #(
  parameter int N_NODES = 8,
  parameter int AGE_W   = 8,
  parameter int DEPTH_W = 4,
  parameter int ID_W    = 6,
  localparam int IDX_W  = $clog2(N_NODES)
) (
  input  logic [N_NODES-1:0]         elig,
  input  logic [N_NODES*AGE_W-1:0]   ages,
  input  logic [N_NODES*DEPTH_W-1:0] depth,
  input  logic [N_NODES*ID_W-1:0]    node_id,
  output logic                       found,
  output logic [IDX_W-1:0]           win_idx,
  output logic [ID_W-1:0]            win_id
);

  logic [AGE_W-1:0]   age_a [N_NODES];
  logic [DEPTH_W-1:0] hop_a [N_NODES];
  logic [ID_W-1:0]    nid_a [N_NODES];

  for (genvar g = 0; g < N_NODES; g++) begin : g_unpack
    assign age_a[g] = ages[g*AGE_W +: AGE_W];
    assign hop_a[g] = depth[g*DEPTH_W +: DEPTH_W];
    assign nid_a[g] = node_id[g*ID_W +: ID_W];
  end

  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    for (int i = 0; i < N_NODES; i++) begin
      if (elig[i] && (!found || fta_pkg::ahead_of(
            32'(age_a[i]), 32'(hop_a[i]), 32'(nid_a[i]),
            32'(age_a[win_idx]), 32'(hop_a[win_idx]), 32'(nid_a[win_idx])))) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
    win_id = nid_a[win_idx];
  end

endmodule

// File: rtl/fta_fair_ctrl.sv
module fta_fair_ctrl #(
  parameter int N_NODES = 8,
  parameter int RATIO   = 3,
  localparam int CNT_W  = $clog2(RATIO + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_NODES-1:0] req,
  input  logic [N_NODES-1:0] urgent,
  input  logic               idle,
  input  logic               grant_fire,
  input  logic [N_NODES-1:0] grant_mask,
  output logic [N_NODES-1:0] elig,
  output logic               restart
);

  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(RATIO);

  logic [N_NODES-1:0] perm_q;
  logic [CNT_W-1:0]   ucnt_q;
  logic               normal_wait;
  logic               urgent_ok;
  logic               grant_is_urgent;

  assign normal_wait     = |(req & perm_q & ~urgent);
  assign urgent_ok       = (ucnt_q < CNT_CAP) || !normal_wait;
  assign elig            = req & (perm_q | (urgent & {N_NODES{urgent_ok}}));
  assign restart         = idle && !(&perm_q) && !(|(req & perm_q));
  assign grant_is_urgent = |(grant_mask & urgent);

  always_ff @(posedge clk) begin
    if (rst) begin
      perm_q <= '1;
    end else if (restart) begin
      perm_q <= '1;
    end else if (grant_fire) begin
      perm_q <= perm_q & ~grant_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ucnt_q <= '0;
    end else if (grant_fire) begin
      if (!grant_is_urgent) begin
        ucnt_q <= '0;
      end else if (ucnt_q != CNT_CAP) begin
        ucnt_q <= ucnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/fair_tree_arbiter.sv
module fair_tree_arbiter #(
  parameter int N_NODES = 8,
  parameter int DEPTH_W = 4,
  parameter int ID_W    = 6,
  parameter int AGE_W   = 8,
  parameter int RATIO   = 3
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_NODES-1:0]         req_i,
  input  logic [N_NODES-1:0]         release_i,
  input  logic [N_NODES-1:0]         urgent_i,
  input  logic [N_NODES*DEPTH_W-1:0] depth_i,
  input  logic [N_NODES*ID_W-1:0]    node_id_i,
  output logic [N_NODES-1:0]         grant_o,
  output logic [ID_W-1:0]            grant_id_o,
  output logic                       interval_start_o
);

  localparam int IDX_W = $clog2(N_NODES);

  logic [N_NODES-1:0]       grant_q;
  logic [ID_W-1:0]          gid_q;
  logic                     start_q;
  logic                     idle;
  logic                     rel_hit;
  logic                     restart;
  logic                     found;
  logic                     grant_fire;
  logic [IDX_W-1:0]         win_idx;
  logic [ID_W-1:0]          win_id;
  logic [N_NODES-1:0]       win_mask;
  logic [N_NODES-1:0]       grant_now;
  logic [N_NODES-1:0]       elig;
  logic [N_NODES*AGE_W-1:0] ages;

  assign idle       = !(|grant_q);
  assign rel_hit    = |(release_i & grant_q);
  assign grant_fire = idle && !restart && found;
  assign win_mask   = N_NODES'(1) << win_idx;
  assign grant_now  = grant_fire ? win_mask : '0;

  fta_age_track #(
    .N_NODES (N_NODES),
    .AGE_W   (AGE_W)
  ) u_age (
    .clk        (clk),
    .rst        (rst),
    .req        (req_i),
    .owner_mask (grant_q),
    .grant_now  (grant_now),
    .ages       (ages)
  );

  fta_fair_ctrl #(
    .N_NODES (N_NODES),
    .RATIO   (RATIO)
  ) u_fair (
    .clk        (clk),
    .rst        (rst),
    .req        (req_i),
    .urgent     (urgent_i),
    .idle       (idle),
    .grant_fire (grant_fire),
    .grant_mask (win_mask),
    .elig       (elig),
    .restart    (restart)
  );

  fta_pick #(
    .N_NODES (N_NODES),
    .AGE_W   (AGE_W),
    .DEPTH_W (DEPTH_W),
    .ID_W    (ID_W)
  ) u_pick (
    .elig    (elig),
    .ages    (ages),
    .depth   (depth_i),
    .node_id (node_id_i),
    .found   (found),
    .win_idx (win_idx),
    .win_id  (win_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      gid_q   <= '0;
      start_q <= 1'b0;
    end else begin
      start_q <= restart;
      if (rel_hit) begin
        grant_q <= '0;
        gid_q   <= '0;
      end else if (grant_fire) begin
        grant_q <= win_mask;
        gid_q   <= win_id;
      end
    end
  end

  assign grant_o          = grant_q;
  assign grant_id_o       = gid_q;
  assign interval_start_o = start_q;

endmodule

// File: rtl/fair_tree_arbiter_chk.sv
module fair_tree_arbiter_chk #(
  parameter int N_NODES = 8,
  parameter int ID_W    = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [N_NODES-1:0] release_i,
  input logic [N_NODES-1:0] grant_o,
  input logic [ID_W-1:0]    grant_id_o,
  input logic               interval_start_o
);

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (grant_o == '0) && (grant_id_o == '0) && !interval_start_o);

  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));

  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    ((grant_o != '0) && ((release_i & grant_o) == '0)) |=>
      ($stable(grant_o) && $stable(grant_id_o)));

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    ((release_i & grant_o) != '0) |=> (grant_o == '0));

  p_idle_id_r2: assert property (@(posedge clk) disable iff (rst)
    (grant_o == '0) |-> (grant_id_o == '0));

  p_start_idle_r8: assert property (@(posedge clk) disable iff (rst)
    interval_start_o |-> (grant_o == '0));

  p_start_single_r8: assert property (@(posedge clk) disable iff (rst)
    interval_start_o |=> !interval_start_o);

endmodule

bind fair_tree_arbiter fair_tree_arbiter_chk #(
  .N_NODES (N_NODES),
  .ID_W    (ID_W)
) u_chk (
  .clk              (clk),
  .rst              (rst),
  .release_i        (release_i),
  .grant_o          (grant_o),
  .grant_id_o       (grant_id_o),
  .interval_start_o (interval_start_o)
);

// File: tb/fair_tree_arbiter_tb.sv
module fair_tree_arbiter_tb;

  localparam int N   = 8;
  localparam int DW  = 4;
  localparam int IW  = 6;
  localparam int RAT = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [N-1:0]    req = '0;
  logic [N-1:0]    rel = '0;
  logic [N-1:0]    urg = '0;
  logic [N*DW-1:0] depth_v;
  logic [N*IW-1:0] id_v;
  logic [N-1:0]    grant_o;
  logic [IW-1:0]   grant_id_o;
  logic            interval_start_o;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  int hop [N] = '{2, 2, 3, 1, 3, 1, 2, 3};
  int nid [N];

  always #2.5 clk = ~clk;

  fair_tree_arbiter #(
    .N_NODES (N), .DEPTH_W (DW), .ID_W (IW), .AGE_W (8), .RATIO (RAT)
  ) u_dut (
    .clk (clk), .rst (rst), .req_i (req), .release_i (rel), .urgent_i (urg),
    .depth_i (depth_v), .node_id_i (id_v), .grant_o (grant_o),
    .grant_id_o (grant_id_o), .interval_start_o (interval_start_o)
  );

  // reference model state
  int q [$];
  int arrivals [$];
  bit perm_m [N];
  int owner_m = -1;
  int ucnt_m  = 0;
  bit pulse_m = 0;
  bit model_live = 0;

  function automatic bit in_queue(int n);
    foreach (q[k]) if (q[k] == n) return 1;
    return 0;
  endfunction

  function automatic bit ahead(int a, int b);
    if (hop[a] != hop[b]) return hop[a] < hop[b];
    return nid[a] < nid[b];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete();
      for (int i = 0; i < N; i++) perm_m[i] = 1;
      owner_m = -1; ucnt_m = 0; pulse_m = 0; model_live = 1;
    end else begin
      for (int k = q.size() - 1; k >= 0; k--) if (!req[q[k]]) q.delete(k);
      arrivals.delete();
      for (int i = 0; i < N; i++)
        if (req[i] && i != owner_m && !in_queue(i)) arrivals.push_back(i);
      while (arrivals.size() > 0) begin
        int b;
        b = 0;
        for (int k = 1; k < arrivals.size(); k++) if (ahead(arrivals[k], arrivals[b])) b = k;
        q.push_back(arrivals[b]);
        arrivals.delete(b);
      end
      pulse_m = 0;
      if (owner_m >= 0) begin
        if (rel[owner_m]) owner_m = -1;
      end else begin
        bit all_set, perm_req, nwait;
        all_set = 1; perm_req = 0; nwait = 0;
        for (int i = 0; i < N; i++) begin
          if (!perm_m[i]) all_set = 0;
          if (req[i] && perm_m[i]) perm_req = 1;
          if (req[i] && perm_m[i] && !urg[i]) nwait = 1;
        end
        if (!all_set && !perm_req) begin
          for (int i = 0; i < N; i++) perm_m[i] = 1;
          pulse_m = 1;
        end else begin
          for (int k = 0; k < q.size(); k++) begin
            int n;
            n = q[k];
            if (perm_m[n] || (urg[n] && (ucnt_m < RAT || !nwait))) begin
              owner_m   = n;
              perm_m[n] = 0;
              ucnt_m    = urg[n] ? ((ucnt_m < RAT) ? ucnt_m + 1 : RAT) : 0;
              q.delete(k);
              break;
            end
          end
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && model_live) begin
      logic [N-1:0]  eg;
      logic [IW-1:0] ei;
      eg = (owner_m >= 0) ? (N'(1) << owner_m) : '0;
      ei = (owner_m >= 0) ? IW'(nid[owner_m]) : '0;
      checks++;
      if (grant_o !== eg || grant_id_o !== ei) begin
        errors++;
        $display("FAIL R2 cycle %0d: grant %b id %0d, expected %b id %0d",
                 cyc, grant_o, grant_id_o, eg, ei);
      end
      checks++;
      if (interval_start_o !== pulse_m) begin
        errors++;
        $display("FAIL R8 cycle %0d: interval_start %b, expected %b",
                 cyc, interval_start_o, pulse_m);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_owner(string tag, int idx);
    for (int w = 0; w < 30; w++) begin
      if (grant_o != '0) break;
      @(negedge clk);
    end
    check(tag, 32'(grant_o), 32'(N'(1) << idx));
    check(tag, 32'(grant_id_o), 32'(nid[idx]));
  endtask

  task automatic drop_owner(int idx, bit keep);
    rel[idx] = 1'b1;
    req[idx] = keep;
    @(negedge clk);
    rel[idx] = 1'b0;
    check("R3 grant withdrawn after release", 32'(grant_o), 32'h0);
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      nid[i] = 40 - 5 * i;
      depth_v[i*DW +: DW] = DW'(hop[i]);
      id_v[i*IW +: IW]    = IW'(nid[i]);
    end
    tick(4);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset grant", 32'(grant_o), 32'h0);
    check("R1 reset id", 32'(grant_id_o), 32'h0);
    check("R1 reset pulse", 32'(interval_start_o), 32'h0);

    // R1: flags set after reset, lone request granted at once
    req[0] = 1'b1;
    @(negedge clk);
    check("R1 immediate grant", 32'(grant_o), 32'h1);
    drop_owner(0, 0);
    @(negedge clk);
    check("R8 round reopens", 32'(interval_start_o), 32'h1);
    tick(3);

    // R5: simultaneous arrivals, fewer hops wins
    req[2] = 1'b1; req[5] = 1'b1;
    @(negedge clk);
    expect_owner("R5 hop tie-break", 5);
    drop_owner(5, 0);
    expect_owner("R5 second", 2);
    drop_owner(2, 0);
    tick(4);

    // R6: equal hops, lower identifier wins
    req[1] = 1'b1; req[6] = 1'b1;
    @(negedge clk);
    expect_owner("R6 id tie-break", 6);
    drop_owner(6, 0);
    expect_owner("R6 second", 1);
    drop_owner(1, 0);
    tick(4);

    // R4 and R2: arrival order, foreign release ignored
    req[3] = 1'b1;
    @(negedge clk);
    expect_owner("R4 setup", 3);
    req[7] = 1'b1; tick(2);
    req[0] = 1'b1; tick(1);
    rel[0] = 1'b1; @(negedge clk); rel[0] = 1'b0;
    check("R2 foreign release ignored", 32'(grant_o), 32'(N'(1) << 3));
    tick(1);
    drop_owner(3, 0);
    expect_owner("R4 oldest wins", 7);
    drop_owner(7, 0);
    expect_owner("R4 next", 0);
    drop_owner(0, 0);
    tick(4);

    // R12: withdrawal forfeits waiting time
    req[3] = 1'b1;
    @(negedge clk);
    expect_owner("R12 setup", 3);
    req[7] = 1'b1; tick(2);
    req[0] = 1'b1; tick(1);
    req[7] = 1'b0; tick(1);
    req[7] = 1'b1; tick(1);
    drop_owner(3, 0);
    expect_owner("R12 withdrawn loses age", 0);
    drop_owner(0, 0);
    expect_owner("R12 rejoined", 7);
    drop_owner(7, 0);
    tick(4);

    // R7: spent permission blocks an older non-urgent requester
    req[4] = 1'b1; req[2] = 1'b1;
    @(negedge clk);
    expect_owner("R7 setup", 4);
    drop_owner(4, 1);
    expect_owner("R7 next holder", 2);
    tick(2); req[1] = 1'b1; tick(2);
    drop_owner(2, 0);
    expect_owner("R7 spent node skipped", 1);
    drop_owner(1, 0);
    @(negedge clk);
    check("R8 pulse on reopen", 32'(interval_start_o), 32'h1);
    expect_owner("R8 reenabled node", 4);
    drop_owner(4, 0);
    tick(4);

    // R9: urgent node wins without permission
    urg[5] = 1'b1;
    req[5] = 1'b1; req[3] = 1'b1;
    @(negedge clk);
    expect_owner("R9 setup", 5);
    drop_owner(5, 0);
    expect_owner("R9 normal turn", 3);
    req[5] = 1'b1; tick(2);
    req[2] = 1'b1; tick(2);
    drop_owner(3, 0);
    expect_owner("R9 urgent override", 5);
    drop_owner(5, 0);
    expect_owner("R9 after", 2);
    drop_owner(2, 0);
    tick(4);

    // R10: cap reached, waiting normal node takes its turn
    urg[6] = 1'b1; urg[7] = 1'b1;
    req[5] = 1'b1; req[6] = 1'b1; req[7] = 1'b1;
    @(negedge clk);
    expect_owner("R10 first", 5);
    drop_owner(5, 0);
    expect_owner("R10 second", 6);
    drop_owner(6, 0);
    expect_owner("R10 third", 7);
    req[5] = 1'b1; tick(2);
    req[1] = 1'b1; tick(2);
    drop_owner(7, 0);
    expect_owner("R10 cap blocks urgent", 1);
    drop_owner(1, 0);
    expect_owner("R10 urgent after reset of count", 5);
    drop_owner(5, 0);
    tick(4);

    // R11: only urgent requesters, cap does not block
    urg[4] = 1'b1;
    req[5] = 1'b1; req[6] = 1'b1; req[7] = 1'b1;
    @(negedge clk);
    expect_owner("R11 first", 5);
    drop_owner(5, 0);
    expect_owner("R11 second", 6);
    drop_owner(6, 0);
    expect_owner("R11 third", 7);
    req[5] = 1'b1; tick(2);
    req[4] = 1'b1; tick(2);
    drop_owner(7, 0);
    expect_owner("R11 urgent unblocked", 5);
    drop_owner(5, 0);
    expect_owner("R11 after", 4);
    drop_owner(4, 0);
    tick(4);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule